// File: doc/BRIEF.md
# Shared Frame Memory Switch

This block decides which of two masters may reach a single picture store: a processor, through which a host fills the store, or a display refresh engine that reads pixels out at a steady pace. Access is not shared cycle by cycle. Exactly one switch path is open at any moment, and the other master is cut off from the address, data and control lines. The processor owns the store by default. When the refresh request is raised, ownership passes to the refresh side after one clock in which nobody drives the bus. When the request is dropped, ownership returns the same way.

While the refresh side owns the store, an internal address generator walks a stereo pair of square images. It covers the left image row by row and then the right one, and it reads one byte per byte period. The byte period is derived from the clock period by a divider. The low six bits of each byte, a gray level, are presented on a pixel output with a strobe. A frame-done flag marks the last byte of the pair. A processor access made while the refresh side owns the store sees ready held low. The access is kept waiting and is carried out once the processor path reopens.

The store is assumed to be synchronous with a one-clock read latency.

Top module: `frame_mem_switch`

## Requirements
- R1: After reset the processor path is enabled, the refresh path is disabled, cpu_ready is high, and pix_strobe and frame_done are low. The first pixel read after reset comes from address 0.
- R2: cpu_path_en and gfx_path_en are never high together. In any cycle where both are low, mem_en and mem_we are low.
- R3: A rise of refresh_req gives one idle clock with both paths off, and then gfx_path_en goes high. A fall gives one idle clock, and then cpu_path_en goes high again.
- R4: While cpu_path_en is low, cpu_ready is low and no write reaches the store. A request that is held is carried out in the first cycle in which cpu_ready is high. A request made in the last processor-owned cycle before a switchover is carried out in that cycle.
- R5: Refresh reads visit addresses in steps of one. The left image occupies addresses 0 to IMG_DIM*IMG_DIM-1 in row-major order, and the right image follows. pix_data is bits 5:0 of the byte read.
- R6: The refresh side reads once every DIV = BYTE_PERIOD_NS/CLK_PERIOD_NS clocks. The first read falls in the first refresh-owned cycle, so a span of G refresh-owned cycles gives ceil(G/DIV) reads.
- R7: After the byte at address NUM_IMG*IMG_DIM*IMG_DIM-1, the read address wraps to 0. frame_done is high together with pix_strobe for that byte only.
- R8: The scan position is kept while the processor owns the store. The next refresh span resumes at the following address.
- R9: pix_strobe rises two clocks after the cycle in which the refresh read is issued on the memory port.
- R10: While the processor owns the store, its reads return mem_rdata on cpu_rdata one clock after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_req | input | 1 | High while the display wants the store |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | Processor write when high, read when low |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Processor read data |
| cpu_ready | output | 1 | Processor access accepted this cycle |
| cpu_path_en | output | 1 | Processor switch path open |
| gfx_path_en | output | 1 | Refresh switch path open |
| mem_en | output | 1 | Store access enable |
| mem_we | output | 1 | Store write enable |
| mem_addr | output | ADDR_W | Store address |
| mem_wdata | output | DATA_W | Store write data |
| mem_rdata | input | DATA_W | Store read data, one clock after mem_en |
| pix_data | output | PIX_BITS | Gray level of the current pixel |
| pix_strobe | output | 1 | pix_data valid |
| frame_done | output | 1 | Current pixel is the last of the stereo pair |

## Verification
Two coincidences matter here. In the first, a processor write arrives in the same cycle that refresh_req rises. In the second, a processor write is raised while the refresh side owns the store and is kept waiting across the whole span. The bench drives both inputs on the same clock edge for the first case. It then checks that the write was accepted at once, that the following cycle is idle, and that the refresh reads already see the new byte. For the second case, the bench counts the cycles the write waits against the number implied by the switchover timing. It then reads the byte back through the processor path.

// File: rtl/fms_pkg.sv
package fms_pkg;

    typedef enum logic [1:0] {
        OWN_CPU     = 2'd0,
        OWN_GAP_IN  = 2'd1,
        OWN_GFX     = 2'd2,
        OWN_GAP_OUT = 2'd3
    } owner_e;

endpackage

// File: rtl/fms_owner_ctrl.sv
module fms_owner_ctrl
    import fms_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic refresh_req,
    output logic cpu_path_en,
    output logic gfx_path_en
);

    typedef struct packed {
        owner_e owner;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.owner)
            OWN_CPU:     if (refresh_req)  st_d.owner = OWN_GAP_IN;
            OWN_GAP_IN:                    st_d.owner = OWN_GFX;
            OWN_GFX:     if (!refresh_req) st_d.owner = OWN_GAP_OUT;
            OWN_GAP_OUT:                   st_d.owner = OWN_CPU;
            default:                       st_d.owner = OWN_CPU;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{owner: OWN_CPU};
        else        st_q <= st_d;
    end

    assign cpu_path_en = (st_q.owner == OWN_CPU);
    assign gfx_path_en = (st_q.owner == OWN_GFX);

    AST_NO_DIRECT_TO_GFX: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_CPU) |=> (st_q.owner != OWN_GFX)); // R3
    AST_NO_DIRECT_TO_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_GFX) |=> (st_q.owner != OWN_CPU)); // R3

endmodule

// File: rtl/fms_byte_pacer.sv
module fms_byte_pacer #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    generate
        if (DIV > 1) begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] TOP = CW'(DIV - 1);

            typedef struct packed {
                logic [CW-1:0] cnt;
            } pace_t;

            pace_t pc_d, pc_q;

            always_comb begin
                pc_d = pc_q;
                if (!run)               pc_d.cnt = '0;
                else if (pc_q.cnt == TOP) pc_d.cnt = '0;
                else                    pc_d.cnt = pc_q.cnt + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) pc_q <= '0;
                else        pc_q <= pc_d;
            end

            assign tick = run && (pc_q.cnt == '0);

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R6
        end else begin : g_every
            assign tick = run;
        end
    endgenerate

endmodule

// File: rtl/fms_scan_addr.sv
module fms_scan_addr #(
    parameter int DEPTH  = 32768,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } scan_t;

    scan_t sc_d, sc_q;

    assign last = (sc_q.addr == LAST_A);
    assign addr = sc_q.addr;

    always_comb begin
        sc_d = sc_q;
        if (adv) begin
            if (last) sc_d.addr = '0;
            else      sc_d.addr = sc_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !last) |=> (addr == $past(addr) + ADDR_W'(1))); // R5
    AST_SCAN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last) |=> (addr == '0)); // R7
    AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(addr)); // R8

endmodule

// File: rtl/frame_mem_switch.sv
module frame_mem_switch #(
    parameter int CLK_PERIOD_NS  = 8,
    parameter int BYTE_PERIOD_NS = 2000,
    parameter int IMG_DIM        = 128,
    parameter int NUM_IMG        = 2,
    parameter int DATA_W         = 8,
    parameter int PIX_BITS       = 6,
    parameter int ADDR_W         = $clog2(NUM_IMG * IMG_DIM * IMG_DIM)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                refresh_req,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                cpu_ready,
    output logic                cpu_path_en,
    output logic                gfx_path_en,
    output logic                mem_en,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [PIX_BITS-1:0] pix_data,
    output logic                pix_strobe,
    output logic                frame_done
);

    localparam int DIV   = BYTE_PERIOD_NS / CLK_PERIOD_NS;
    localparam int DEPTH = NUM_IMG * IMG_DIM * IMG_DIM;

    logic              tick;
    logic [ADDR_W-1:0] scan_addr;
    logic              scan_last;

    fms_owner_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .refresh_req (refresh_req),
        .cpu_path_en (cpu_path_en),
        .gfx_path_en (gfx_path_en)
    );

    fms_byte_pacer #(.DIV(DIV)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (gfx_path_en),
        .tick  (tick)
    );

    fms_scan_addr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (tick),
        .addr  (scan_addr),
        .last  (scan_last)
    );

    // Switch paths: only the open path reaches the store.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (cpu_path_en) begin
            mem_en    = cpu_req;
            mem_we    = cpu_req && cpu_we;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
        end else if (gfx_path_en) begin
            mem_en    = tick;
            mem_addr  = scan_addr;
        end
    end

    assign cpu_ready = cpu_path_en;
    assign cpu_rdata = mem_rdata;

    // Pixel pipeline: read issued, data back one clock later, registered out.
    typedef struct packed {
        logic                rd_pend;
        logic                rd_last;
        logic [PIX_BITS-1:0] pix;
        logic                strobe;
        logic                done;
    } pipe_t;

    pipe_t pp_d, pp_q;

    always_comb begin
        pp_d         = pp_q;
        pp_d.rd_pend = tick;
        pp_d.rd_last = tick && scan_last;
        pp_d.strobe  = pp_q.rd_pend;
        pp_d.done    = pp_q.rd_last;
        if (pp_q.rd_pend) pp_d.pix = mem_rdata[PIX_BITS-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    assign pix_data   = pp_q.pix;
    assign pix_strobe = pp_q.strobe;
    assign frame_done = pp_q.done;

    AST_PATHS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_path_en && gfx_path_en)); // R2
    AST_BUS_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_path_en && !gfx_path_en) |-> (!mem_en && !mem_we)); // R2
    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ready) |-> !mem_we); // R4
    AST_DONE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> pix_strobe); // R7
    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        pix_strobe |-> $past(gfx_path_en && mem_en && !mem_we, 2)); // R9

endmodule

// File: tb/frame_mem_switch_test.sv
module frame_mem_switch_test;

    localparam int CLK_NS = 8;
    localparam int BYTE_NS = 40;
    localparam int DIM = 4;
    localparam int NIMG = 2;
    localparam int DIV = BYTE_NS / CLK_NS;
    localparam int DEPTH = NIMG * DIM * DIM;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic refresh_req = 1'b0;
    logic cpu_req = 1'b0;
    logic cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic cpu_ready, cpu_path_en, gfx_path_en;
    logic mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = '0;
    logic [5:0] pix_data;
    logic pix_strobe, frame_done;

    always #(CLK_NS/2) clk = ~clk;

    frame_mem_switch #(
        .CLK_PERIOD_NS(CLK_NS), .BYTE_PERIOD_NS(BYTE_NS),
        .IMG_DIM(DIM), .NUM_IMG(NIMG), .DATA_W(8), .PIX_BITS(6)
    ) uut (
        .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .cpu_path_en(cpu_path_en), .gfx_path_en(gfx_path_en),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pix_data(pix_data), .pix_strobe(pix_strobe), .frame_done(frame_done)
    );

    // Synchronous store model, one clock read latency.
    logic [7:0] store [DEPTH];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) store[mem_addr] <= mem_wdata;
            mem_rdata <= store[mem_addr];
        end
    end

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Scoreboard
    typedef struct {
        int  pix;
        bit  last;
    } exp_t;
    exp_t exp_q[$];
    logic [7:0] shadow [DEPTH];
    bit seg_first = 1;
    int seg_pops = 0;
    int prev_strobe = 0;
    int last_rd = -10;

    task automatic load_expect(input int start);
        exp_q.delete();
        for (int k = 0; k < 64; k++) begin
            int a;
            exp_t e;
            a = (start + k) % DEPTH;
            e.pix = int'(shadow[a] & 8'h3F);
            e.last = (a == DEPTH - 1);
            exp_q.push_back(e);
        end
        seg_first = 1;
        seg_pops = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(!(cpu_path_en && gfx_path_en), "R2", "both paths open", 1, 0);
            if (!cpu_path_en && !gfx_path_en)
                chk(!mem_en && !mem_we, "R2", "bus active in idle clock", int'(mem_en), 0);
            if (!cpu_path_en)
                chk(!cpu_ready && !mem_we, "R4", "ready/write while cut off", int'(cpu_ready), 0);
            if (gfx_path_en && mem_en) last_rd = cyc;
            if (!pix_strobe)
                chk(!frame_done, "R7", "frame_done without strobe", int'(frame_done), 0);
            if (pix_strobe) begin
                chk(cyc - last_rd == 2, "R9", "strobe latency", cyc - last_rd, 2);
                if (!seg_first)
                    chk(cyc - prev_strobe == DIV, "R6", "byte period", cyc - prev_strobe, DIV);
                seg_first = 0;
                prev_strobe = cyc;
                if (exp_q.size() == 0) begin
                    chk(0, "R5", "unexpected pixel", int'(pix_data), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    seg_pops++;
                    chk(int'(pix_data) == e.pix, "R5", "pixel value", int'(pix_data), e.pix);
                    chk(frame_done == e.last, "R7", "frame_done", int'(frame_done), int'(e.last));
                end
            end
        end
    end

    task automatic cpu_access(input bit we, input int addr, input int wd,
                              output int waited, output int rd);
        @(negedge clk);
        cpu_req = 1'b1;
        cpu_we = we;
        cpu_addr = AW'(addr);
        cpu_wdata = 8'(wd);
        waited = 0;
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
            waited++;
        end
        @(negedge clk);
        cpu_req = 1'b0;
        cpu_we = 1'b0;
        rd = int'(cpu_rdata);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int w, r, ptr;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(cpu_path_en == 1'b1, "R1", "cpu_path_en", int'(cpu_path_en), 1);
        chk(gfx_path_en == 1'b0, "R1", "gfx_path_en", int'(gfx_path_en), 0);
        chk(cpu_ready == 1'b1, "R1", "cpu_ready", int'(cpu_ready), 1);
        chk(!pix_strobe && !frame_done, "R1", "strobe/done", int'(pix_strobe), 0);

        // Preload both images through the processor path
        for (int a = 0; a < DEPTH; a++) begin
            shadow[a] = 8'((a * 37 + 91) & 255);
            cpu_access(1'b1, a, int'(shadow[a]), w, r);
        end
        cpu_access(1'b0, DEPTH - 1, 0, w, r);
        chk(r == int'(shadow[DEPTH-1]), "R10", "cpu readback", r, int'(shadow[DEPTH-1]));

        // Segment A: write coincides with the refresh request edge
        shadow[5] = 8'hEA;
        load_expect(0);
        @(negedge clk);
        refresh_req = 1'b1;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = AW'(5); cpu_wdata = 8'hEA;
        #1;
        chk(cpu_ready == 1'b1, "R4", "ready in last cpu cycle", int'(cpu_ready), 1);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        chk(!cpu_path_en && !gfx_path_en, "R3", "idle clock on entry", int'(gfx_path_en), 0);
        chk(store[5] == 8'hEA, "R4", "coincident write landed", int'(store[5]), 'hEA);
        @(negedge clk);
        chk(gfx_path_en == 1'b1, "R3", "refresh path after gap", int'(gfx_path_en), 1);
        repeat (199) @(negedge clk);
        refresh_req = 1'b0;
        repeat (6) @(negedge clk);
        chk(seg_pops == 40, "R6", "reads in 200 refresh cycles", seg_pops, 40);
        ptr = (0 + seg_pops) % DEPTH;

        // Segment B: resume position, processor write stalled across the span
        load_expect(ptr);
        fork
            begin
                @(negedge clk);
                refresh_req = 1'b1;
                repeat (51) @(negedge clk);
                refresh_req = 1'b0;
                @(negedge clk);
                chk(!cpu_path_en && !gfx_path_en, "R3", "idle clock on exit", int'(cpu_path_en), 0);
                @(negedge clk);
                chk(cpu_path_en == 1'b1, "R3", "cpu path after gap", int'(cpu_path_en), 1);
            end
            begin
                int w2, r2;
                repeat (2) @(negedge clk);
                cpu_access(1'b1, 2, 'hFF, w2, r2);
                chk(w2 == 51, "R4", "cycles stalled", w2, 51);
            end
        join
        repeat (4) @(negedge clk);
        chk(seg_pops == 10, "R8", "reads in resumed span", seg_pops, 10);
        shadow[2] = 8'hFF;

        cpu_access(1'b0, 2, 0, w, r);
        chk(r == 'hFF, "R4", "stalled write readback", r, 'hFF);
        cpu_access(1'b0, 5, 0, w, r);
        chk(r == 'hEA, "R10", "coincident write readback", r, 'hEA);
        chk(exp_q.size() == 54, "R8", "scoreboard residue", exp_q.size(), 54);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule